// File: doc/BRIEF.md
# DRAM Bank Read Command Sequencer

This block turns read requests for a single DRAM bank into a correctly spaced stream of ACTIVATE, READ and PRECHARGE commands. A request carries a row and a column and is taken over a ready/valid handshake while the sequencer is idle. The block keeps track of whether a row is open in the bank and which one. From that it picks one of three paths: page-empty (activate, then read), row hit (read only) or page miss (precharge, activate, then read). It then marks the cycles in which the data burst is on the bus.

Three timing values, all counted in clock cycles, set the command spacing: row-to-column delay, CAS latency and precharge time. They are parameters, and a 12-12-12 part is the default. An 8-beat double-data-rate burst takes four clock cycles. A mode input chooses the page policy for each request. In closed-page mode the bank is precharged after the burst. In open-page mode the row stays open for the next request. One-cycle hit and miss pulses are provided for performance counting.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of an access, req_ready is 1, cmd is NOP, data_valid is 0 and row_open is 0.
- R2: A request is taken only in a cycle where req_ready and req_valid are both 1. req_ready is 0 from the cycle after acceptance until the access completes. A request held valid while the block is busy is taken once req_ready returns, and its row and column are used.
- R3: The cmd encoding is 2'b00 NOP, 2'b01 ACTIVATE, 2'b10 READ and 2'b11 PRECHARGE. When no row is open, ACTIVATE is issued in the cycle after acceptance with cmd_row equal to the request row. READ follows T_RCD cycles after ACTIVATE, with cmd_col equal to the request column.
- R4: data_valid rises exactly T_CL cycles after READ and stays high for exactly BURST_BEATS/2 consecutive cycles. burst_start is high in the first of those cycles and burst_end in the last.
- R5: The page policy is sampled at acceptance, with open_page_mode=0 meaning closed-page. In closed-page mode PRECHARGE is issued in the cycle after the last data cycle, and req_ready returns T_RP cycles after that PRECHARGE.
- R6: A request whose row matches the open row is a hit. READ is issued in the cycle after acceptance, and no ACTIVATE or PRECHARGE precedes it.
- R7: A request to a different row while a row is open is a miss. PRECHARGE is issued in the cycle after acceptance, ACTIVATE T_RP cycles later and READ T_RCD cycles after that.
- R8: In open-page mode no PRECHARGE follows the burst, and req_ready returns in the cycle after the last data cycle.
- R9: row_open becomes 1 in the cycle after an ACTIVATE and 0 in the cycle after a PRECHARGE. READ is issued only while it is 1, and ACTIVATE only while it is 0.
- R10: row_hit pulses for one cycle, the cycle after acceptance, for each hit. page_miss does the same for each miss. A page-empty request pulses neither, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_page_mode | input | 1 | 1 = leave the row open after the access, 0 = precharge after it |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| cmd | output | 2 | Command to the bank (NOP/ACT/READ/PRE) |
| cmd_row | output | ROW_W | Row that goes with ACTIVATE |
| cmd_col | output | COL_W | Column that goes with READ |
| data_valid | output | 1 | Burst data on the bus this cycle |
| burst_start | output | 1 | First cycle of the burst |
| burst_end | output | 1 | Last cycle of the burst |
| row_hit | output | 1 | One-cycle pulse for a row hit |
| page_miss | output | 1 | One-cycle pulse for a page miss |
| row_open | output | 1 | A row is currently open in the bank |

## Verification
The bound checker watches the spacing rules on every cycle. It counts cycles since the last ACTIVATE, READ and PRECHARGE to prove the T_RCD and T_RP minimums and the exact T_CL offset. It also checks that READ and ACTIVATE agree with the row state, that the hit and miss pulses line up with the first command, and that an idle block issues nothing. Which path a request takes, the exact cycle at which each command appears, the burst length, when req_ready returns under each policy, and a stalled request being taken with its own row can only be shown by the bench's request sequences. These are a table of empty, hit and miss requests in both modes, a stall, and a reset during a burst.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'b00,
      CMD_ACT = 2'b01,
      CMD_RD  = 2'b10,
      CMD_PRE = 2'b11
   } dram_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_WRP,
      ST_ACT,
      ST_WRCD,
      ST_RD,
      ST_WCL,
      ST_BURST,
      ST_CPRE,
      ST_CWRP
   } seq_state_e;

endpackage

// File: rtl/dram_rd_wait_ctr.sv
module dram_rd_wait_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign count = cnt_q;
   assign done  = (cnt_q == '0);

endmodule

// File: rtl/dram_rd_row_track.sv
module dram_rd_row_track #(
   parameter int ROW_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] set_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             is_open,
   output logic             is_hit
);

   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (close) begin
         open_q <= 1'b0;
      end else if (open_set) begin
         open_q <= 1'b1;
         row_q  <= set_row;
      end
   end

   assign is_open = open_q;
   assign is_hit  = open_q && (row_q == cmp_row);

endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
   import dram_rd_pkg::*;
#(
   parameter int ROW_W       = 15,
   parameter int COL_W       = 10,
   parameter int T_CL        = 12,
   parameter int T_RCD       = 12,
   parameter int T_RP        = 12,
   parameter int BURST_BEATS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_page_mode,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   output logic [1:0]       cmd,
   output logic [ROW_W-1:0] cmd_row,
   output logic [COL_W-1:0] cmd_col,
   output logic             data_valid,
   output logic             burst_start,
   output logic             burst_end,
   output logic             row_hit,
   output logic             page_miss,
   output logic             row_open
);

   localparam int BURST_CYC = BURST_BEATS / 2;
   localparam int MAX_A     = (T_CL > T_RCD) ? T_CL : T_RCD;
   localparam int MAX_B     = (T_RP > BURST_CYC) ? T_RP : BURST_CYC;
   localparam int MAX_T     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W     = $clog2(MAX_T + 1);

   localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 2);
   localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 2);
   localparam logic [CNT_W-1:0] LD_CL    = CNT_W'(T_CL - 2);
   localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_CYC - 1);

   // elaboration-time parameter checks
   if (T_CL < 2) begin : g_bad_cl
      $error("T_CL must be at least 2");
   end
   if (T_RCD < 2) begin : g_bad_rcd
      $error("T_RCD must be at least 2");
   end
   if (T_RP < 2) begin : g_bad_rp
      $error("T_RP must be at least 2");
   end
   if ((BURST_BEATS < 2) || (BURST_BEATS % 2 != 0)) begin : g_bad_bl
      $error("BURST_BEATS must be even and at least 2");
   end
   if ((ROW_W < 1) || (COL_W < 1)) begin : g_bad_w
      $error("address widths must be positive");
   end

   seq_state_e       state_q, state_d;
   logic             accept;
   logic             ctr_load, ctr_done;
   logic [CNT_W-1:0] ctr_val, ctr_cnt;
   logic             trk_open, trk_hit;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             pol_open_q;
   logic             hit_q, miss_q;

   assign accept = (state_q == ST_IDLE) && req_valid;

   // next-state selection
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (!trk_open)     state_d = ST_ACT;
               else if (trk_hit)  state_d = ST_RD;
               else               state_d = ST_PRE;
            end
         end
         ST_PRE:   if (ctr_done) state_d = ST_WRP;
         ST_WRP:   if (ctr_done) state_d = ST_ACT;
         ST_ACT:   if (ctr_done) state_d = ST_WRCD;
         ST_WRCD:  if (ctr_done) state_d = ST_RD;
         ST_RD:    if (ctr_done) state_d = ST_WCL;
         ST_WCL:   if (ctr_done) state_d = ST_BURST;
         ST_BURST: if (ctr_done) state_d = pol_open_q ? ST_IDLE : ST_CPRE;
         ST_CPRE:  if (ctr_done) state_d = ST_CWRP;
         ST_CWRP:  if (ctr_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   // dwell time of the state being entered
   always_comb begin
      ctr_load = (state_d != state_q);
      unique case (state_d)
         ST_WRP, ST_CWRP: ctr_val = LD_RP;
         ST_WRCD:         ctr_val = LD_RCD;
         ST_WCL:          ctr_val = LD_CL;
         ST_BURST:        ctr_val = LD_BURST;
         default:         ctr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         row_q      <= '0;
         col_q      <= '0;
         pol_open_q <= 1'b0;
         hit_q      <= 1'b0;
         miss_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         hit_q   <= accept && trk_open && trk_hit;
         miss_q  <= accept && trk_open && !trk_hit;
         if (accept) begin
            row_q      <= req_row;
            col_q      <= req_col;
            pol_open_q <= open_page_mode;
         end
      end
   end

   dram_rd_wait_ctr #(.CNT_W(CNT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (ctr_val),
      .count    (ctr_cnt),
      .done     (ctr_done)
   );

   dram_rd_row_track #(.ROW_W(ROW_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_set (state_q == ST_ACT),
      .close    ((state_q == ST_PRE) || (state_q == ST_CPRE)),
      .set_row  (row_q),
      .cmp_row  (req_row),
      .is_open  (trk_open),
      .is_hit   (trk_hit)
   );

   always_comb begin
      unique case (state_q)
         ST_ACT:          cmd = CMD_ACT;
         ST_RD:           cmd = CMD_RD;
         ST_PRE, ST_CPRE: cmd = CMD_PRE;
         default:         cmd = CMD_NOP;
      endcase
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign cmd_row     = row_q;
   assign cmd_col     = col_q;
   assign data_valid  = (state_q == ST_BURST);
   assign burst_start = data_valid && (ctr_cnt == LD_BURST);
   assign burst_end   = data_valid && ctr_done;
   assign row_hit     = hit_q;
   assign page_miss   = miss_q;
   assign row_open    = trk_open;

endmodule

// File: rtl/dram_rd_seq_chk.sv
module dram_rd_seq_chk
   import dram_rd_pkg::*;
#(
   parameter int T_CL  = 12,
   parameter int T_RCD = 12,
   parameter int T_RP  = 12
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic [1:0] cmd,
   input logic       data_valid,
   input logic       burst_end,
   input logic       row_hit,
   input logic       page_miss,
   input logic       row_open
);

   localparam logic [15:0] SAT = 16'hFFFF;

   logic [15:0] since_act, since_rd, since_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act <= SAT;
         since_rd  <= SAT;
         since_pre <= SAT;
      end else begin
         since_act <= (cmd == CMD_ACT) ? 16'd1 : ((since_act == SAT) ? SAT : since_act + 16'd1);
         since_rd  <= (cmd == CMD_RD)  ? 16'd1 : ((since_rd  == SAT) ? SAT : since_rd  + 16'd1);
         since_pre <= (cmd == CMD_PRE) ? 16'd1 : ((since_pre == SAT) ? SAT : since_pre + 16'd1);
      end
   end

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cmd == CMD_NOP) && !data_valid);

   assert_rcd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD) |-> (since_act >= 16'(T_RCD)));

   assert_cl_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> (since_rd == 16'(T_CL)));

   assert_burst_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |=> !data_valid);

   assert_rp_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (since_pre >= 16'(T_RP)));

   assert_hit_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> (cmd == CMD_RD));

   assert_miss_precharges_R7: assert property (@(posedge clk) disable iff (!rst_n)
      page_miss |-> (cmd == CMD_PRE));

   assert_read_needs_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD) |-> row_open);

   assert_act_needs_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> !row_open);

   assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({row_hit, page_miss}));

endmodule

bind dram_rd_seq dram_rd_seq_chk #(
   .T_CL  (T_CL),
   .T_RCD (T_RCD),
   .T_RP  (T_RP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .cmd        (cmd),
   .data_valid (data_valid),
   .burst_end  (burst_end),
   .row_hit    (row_hit),
   .page_miss  (page_miss),
   .row_open   (row_open)
);

// File: tb/test_dram_rd_seq.sv
module test_dram_rd_seq;

   localparam int ROW_W = 8;
   localparam int COL_W = 6;
   localparam int CL    = 5;
   localparam int RCD   = 3;
   localparam int RP    = 4;
   localparam int BCYC  = 4;

   localparam int K_EMPTY = 0;
   localparam int K_HIT   = 1;
   localparam int K_MISS  = 2;

   localparam int NV = 10;
   localparam int V_OPEN [NV] = '{0, 1, 1, 1, 1, 0, 0, 1, 0, 1};
   localparam int V_ROW  [NV] = '{5, 7, 7, 9, 9, 9, 3, 3, 4, 0};
   localparam int V_COL  [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
   localparam int V_KIND [NV] = '{K_EMPTY, K_EMPTY, K_HIT, K_MISS, K_HIT,
                                  K_HIT, K_EMPTY, K_EMPTY, K_MISS, K_EMPTY};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             open_page_mode = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [1:0]       cmd;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;
   logic             data_valid, burst_start, burst_end;
   logic             row_hit, page_miss, row_open;

   int checks = 0;
   int fails  = 0;

   int t_act, t_rd, n_act, n_rd, n_pre, t_pre_last, t_d0, n_dv, t_bs, t_be;
   int t_ready, n_hit, t_hit, n_miss, t_miss, act_row, rd_col, open_after;

   always #10 clk = ~clk;

   dram_rd_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .T_CL(CL), .T_RCD(RCD), .T_RP(RP), .BURST_BEATS(8)
   ) i_dram_rd_seq (
      .clk(clk), .rst_n(rst_n), .open_page_mode(open_page_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
      .cmd(cmd), .cmd_row(cmd_row), .cmd_col(cmd_col), .data_valid(data_valid),
      .burst_start(burst_start), .burst_end(burst_end), .row_hit(row_hit),
      .page_miss(page_miss), .row_open(row_open)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_req(input bit op, input int row, input int col, output int stall);
      @(negedge clk);
      req_valid = 1'b1; open_page_mode = op;
      req_row = ROW_W'(row); req_col = COL_W'(col);
      stall = 0;
      while (!req_ready) begin
         @(negedge clk);
         stall++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      t_act = -1; t_rd = -1; n_act = 0; n_rd = 0; n_pre = 0; t_pre_last = -1;
      t_d0 = -1; n_dv = 0; t_bs = -1; t_be = -1; t_ready = -1;
      n_hit = 0; t_hit = -1; n_miss = 0; t_miss = -1; act_row = -1; rd_col = -1;
      open_after = -1;
      for (int k = 1; k <= 200; k++) begin
         if (cmd == 2'b01) begin n_act++; if (t_act < 0) begin t_act = k; act_row = int'(cmd_row); end end
         if (cmd == 2'b10) begin n_rd++;  if (t_rd < 0)  begin t_rd = k;  rd_col = int'(cmd_col); end end
         if (cmd == 2'b11) begin n_pre++; t_pre_last = k; end
         if (data_valid) begin n_dv++; if (t_d0 < 0) t_d0 = k; end
         if (burst_start) t_bs = k;
         if (burst_end)   t_be = k;
         if (row_hit)   begin n_hit++;  t_hit = k;  end
         if (page_miss) begin n_miss++; t_miss = k; end
         if (req_ready) begin t_ready = k; open_after = int'(row_open); break; end
         @(negedge clk);
      end
   endtask

   task automatic check_req(input bit op, input int kind, input int row, input int col);
      string pt;
      string rp;
      int e_act, e_rd, d0, d3, e_ready, e_pre_n, e_pre_last;
      pt = (kind == K_HIT) ? "R6" : (kind == K_MISS) ? "R7" : "R3";
      rp = op ? "R8" : "R5";
      e_act = (kind == K_EMPTY) ? 1 : (kind == K_MISS) ? 1 + RP : -1;
      e_rd  = (kind == K_HIT) ? 1 : e_act + RCD;
      d0 = e_rd + CL;
      d3 = d0 + BCYC - 1;
      e_pre_n    = ((kind == K_MISS) ? 1 : 0) + (op ? 0 : 1);
      e_pre_last = op ? ((kind == K_MISS) ? 1 : -1) : d3 + 1;
      e_ready    = op ? d3 + 1 : d3 + 1 + RP;
      chk({pt, " ACTIVATE cycle"}, t_act, e_act);
      chk({pt, " ACTIVATE count"}, n_act, (kind == K_HIT) ? 0 : 1);
      chk({pt, " READ cycle"}, t_rd, e_rd);
      chk("R3 single READ", n_rd, 1);
      if (e_act > 0) chk("R3 cmd_row at ACTIVATE", act_row, row);
      chk("R3 cmd_col at READ", rd_col, col);
      chk("R4 first beat cycle", t_d0, d0);
      chk("R4 data_valid cycles", n_dv, BCYC);
      chk("R4 burst_start cycle", t_bs, d0);
      chk("R4 burst_end cycle", t_be, d3);
      chk({rp, " PRECHARGE count"}, n_pre, e_pre_n);
      chk({rp, " last PRECHARGE cycle"}, t_pre_last, e_pre_last);
      chk({rp, " ready return cycle"}, t_ready, e_ready);
      chk("R9 row_open after access", open_after, op ? 1 : 0);
      chk("R10 row_hit pulses", n_hit, (kind == K_HIT) ? 1 : 0);
      chk("R10 page_miss pulses", n_miss, (kind == K_MISS) ? 1 : 0);
      if (kind == K_HIT)  chk("R10 row_hit timing", t_hit, 1);
      if (kind == K_MISS) chk("R10 page_miss timing", t_miss, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int stall;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 req_ready in reset", int'(req_ready), 1);
      chk("R1 cmd in reset", int'(cmd), 0);
      chk("R1 row_open in reset", int'(row_open), 0);
      chk("R1 data_valid in reset", int'(data_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_ready after reset", int'(req_ready), 1);

      // table of request vectors
      for (int v = 0; v < NV; v++) begin
         run_req(V_OPEN[v][0], V_ROW[v], V_COL[v], stall);
         chk("R2 no stall when idle", stall, 0);
         check_req(V_OPEN[v][0], V_KIND[v], V_ROW[v], V_COL[v]);
      end

      // R1: reset in the middle of a burst (row 0 is open, request row 0 is a hit)
      @(negedge clk);
      req_valid = 1'b1; open_page_mode = 1'b1; req_row = '0; req_col = 6'd3;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (CL) @(negedge clk);
      chk("R4 data_valid before mid-burst reset", int'(data_valid), 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 req_ready after mid reset", int'(req_ready), 1);
      chk("R1 row_open after mid reset", int'(row_open), 0);
      chk("R1 data_valid after mid reset", int'(data_valid), 0);
      chk("R1 cmd after mid reset", int'(cmd), 0);
      rst_n = 1'b1;

      // R2: request held valid while busy is stalled, then taken with its own row
      @(negedge clk);
      req_valid = 1'b1; open_page_mode = 1'b0; req_row = 8'd2; req_col = 6'd11;
      @(negedge clk);
      chk("R2 ready low while busy", int'(req_ready), 0);
      run_req(1'b0, 6, 12, stall);
      chk("R2 stall cycles", stall, (1 + RCD + CL + BCYC + RP) - 2);
      check_req(1'b0, K_EMPTY, 6, 12);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule